// File: doc/BRIEF.md
# Clock Rate Checker

This block judges whether a clock runs at the expected rate. It counts rising edges of the clock under test during a window whose length is a fixed number of cycles of a trusted reference clock. At the end of each window it compares the count with a lower bound and an upper bound. It reports the result as a one-cycle valid strobe, together with a too-fast flag and a too-slow flag. All outputs are in the domain of the clock under test.

Starting and stopping use a four-phase handshake with the reference domain. A request crosses into the reference domain. The enable seen there is echoed back, and the control state machine only moves on once the echo agrees with it. Window ends are marked by a toggle in the reference domain. The toggle crosses back as a pulse and becomes the result strobe. A counter that runs past its all-ones value stops there and is reported as too fast.

Top module: `clk_rate_check`

## Requirements
- R1: While either reset is low, the control state is Off and `result_valid_o`, `too_fast_o` and `too_slow_o` are all 0.
- R2: From Off, a high `enable_i` moves the control to Arming. Arming moves to Running only once the reference-domain enable, synchronized back into the measured domain, reads 1.
- R3: From Running, a low `enable_i` moves the control to Draining. Draining returns to Off only once the echoed reference enable reads 0. After that handshake no result is produced.
- R4: The edge counter advances only in Running. Whenever counting is off and the count is nonzero, the count returns to zero on the next edge, and this outranks every other update.
- R5: While its synchronized enable is high, the reference domain closes a window every `WIN_CYC` reference cycles, and its window counter is held at zero while that enable is low. With result strobes N measured cycles apart, the count judged in steady state is N-1, where N = `WIN_CYC` times the clock ratio.
- R6: A result strobe restarts the count at zero and clears the overflow flag on the next edge.
- R7: Counting past the all-ones count sets the overflow flag. The count then stays at all-ones until the next strobe. An overflowed window is reported as too fast regardless of `hi_bound_i`.
- R8: `result_valid_o` is high only in a strobe cycle with a nonzero count, and it is never high on two consecutive cycles.
- R9: `too_fast_o` is high exactly when `result_valid_o` is high and either the count is greater than `hi_bound_i` or overflow is set. A count equal to the bound is not too fast.
- R10: `too_slow_o` is high exactly when `result_valid_o` is high and the count is less than `lo_bound_i`. A count equal to the bound is not too slow.
- R11: An enable pulse of one cycle still completes the whole handshake without producing a result, and a later session measures normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_meas_i | input | 1 | Clock under test |
| rst_meas_ni | input | 1 | Active-low asynchronous reset, measured domain |
| enable_i | input | 1 | Measurement enable, measured domain |
| clk_ref_i | input | 1 | Trusted reference clock |
| rst_ref_ni | input | 1 | Active-low asynchronous reset, reference domain |
| lo_bound_i | input | CNT_W | Smallest acceptable count per window |
| hi_bound_i | input | CNT_W | Largest acceptable count per window |
| result_valid_o | output | 1 | One-cycle strobe: a window closed with a nonzero count |
| too_fast_o | output | 1 | Count above upper bound or overflowed, qualified by valid |
| too_slow_o | output | 1 | Count below lower bound, qualified by valid |

## Verification
A counter that is not cleared or restarted correctly shows up at the first steady window after the fault. In that case the too-fast or too-slow flag at the exact-bound settings flips within one window of `WIN_CYC` reference cycles. A control state machine stuck in Arming or Draining shows up one session later: results stop, or stray strobes appear after disable, and the bench counts these within its quiet gap. An overflow flag that is not held or not cleared changes the flags in the overflow session, or in the first steady window of the in-range session after it.

// File: rtl/clkchk_pkg.sv
package clkchk_pkg;

  typedef enum logic [1:0] {
    CK_OFF      = 2'd0,
    CK_ARMING   = 2'd1,
    CK_RUNNING  = 2'd2,
    CK_DRAINING = 2'd3
  } clkchk_state_e;

endpackage

// File: rtl/clkchk_sync2.sv
module clkchk_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;

endmodule

// File: rtl/clkchk_ctrl.sv
module clkchk_ctrl
  import clkchk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic echo_i,
  output logic req_o,
  output logic count_en_o
);

  clkchk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CK_OFF:      if (enable_i)  state_d = CK_ARMING;
      CK_ARMING:   if (echo_i)    state_d = CK_RUNNING;
      CK_RUNNING:  if (!enable_i) state_d = CK_DRAINING;
      CK_DRAINING: if (!echo_i)   state_d = CK_OFF;
      default:                    state_d = CK_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= CK_OFF;
    else         state_q <= state_d;
  end

  assign req_o      = (state_q == CK_ARMING) || (state_q == CK_RUNNING);
  assign count_en_o = (state_q == CK_RUNNING);

  AST_OFF_TO_ARMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CK_OFF) && enable_i |=> (state_q == CK_ARMING)); // R2
  AST_ARMING_WAITS_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CK_ARMING) && !echo_i |=> (state_q == CK_ARMING)); // R2
  AST_RUN_TO_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CK_RUNNING) && !enable_i |=> (state_q == CK_DRAINING)); // R3
  AST_DRAIN_WAITS_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CK_DRAINING) && echo_i |=> (state_q == CK_DRAINING)); // R3

endmodule

// File: rtl/clkchk_ref_window.sv
module clkchk_ref_window #(
  parameter int unsigned WIN_CYC = 16
) (
  input  logic clk_ref_i,
  input  logic rst_ref_ni,
  input  logic req_i,
  output logic en_ref_o,
  output logic tick_tgl_o
);

  localparam int unsigned WW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam logic [WW-1:0] LAST = WW'(WIN_CYC - 1);

  logic          en_q;
  logic [WW-1:0] win_q, win_d;
  logic          tgl_q, tgl_d;

  clkchk_sync2 #(.W(1)) u_req_sync (
    .clk_i  (clk_ref_i),
    .rst_ni (rst_ref_ni),
    .d_i    (req_i),
    .q_o    (en_q)
  );

  always_comb begin
    win_d = win_q;
    tgl_d = tgl_q;
    if (!en_q) begin
      win_d = '0;
    end else if (win_q == LAST) begin
      win_d = '0;
      tgl_d = ~tgl_q;
    end else begin
      win_d = win_q + WW'(1);
    end
  end

  always_ff @(posedge clk_ref_i or negedge rst_ref_ni) begin
    if (!rst_ref_ni) begin
      win_q <= '0;
      tgl_q <= 1'b0;
    end else begin
      win_q <= win_d;
      tgl_q <= tgl_d;
    end
  end

  assign en_ref_o   = en_q;
  assign tick_tgl_o = tgl_q;

  AST_WIN_PARKED: assert property (@(posedge clk_ref_i) disable iff (!rst_ref_ni)
    !en_q |=> (win_q == '0)); // R5
  AST_TICK_NEEDS_EN: assert property (@(posedge clk_ref_i) disable iff (!rst_ref_ni)
    !en_q |=> $stable(tgl_q)); // R5

endmodule

// File: rtl/clkchk_counter.sv
module clkchk_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             count_en_i,
  input  logic             strobe_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (!count_en_i && (|cnt_q)) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (strobe_i) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (ovf_q) begin
      cnt_d = cnt_q;
    end else if (count_en_i) begin
      if (&cnt_q) ovf_d = 1'b1;
      else        cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  AST_CLEAR_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !count_en_i && (cnt_q != '0) |=> (cnt_q == '0)); // R4
  AST_STROBE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> (cnt_q == '0) && !ovf_q); // R6
  AST_OVF_AT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> (&cnt_q)); // R7
  AST_OVF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q && count_en_i && !strobe_i |=> ovf_q && $stable(cnt_q)); // R7

endmodule

// File: rtl/clk_rate_check.sv
module clk_rate_check #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned WIN_CYC = 16
) (
  input  logic             clk_meas_i,
  input  logic             rst_meas_ni,
  input  logic             enable_i,
  input  logic             clk_ref_i,
  input  logic             rst_ref_ni,
  input  logic [CNT_W-1:0] lo_bound_i,
  input  logic [CNT_W-1:0] hi_bound_i,
  output logic             result_valid_o,
  output logic             too_fast_o,
  output logic             too_slow_o
);

  logic             req;
  logic             count_en;
  logic             en_ref;
  logic             echo;
  logic             tgl_ref;
  logic             tgl_meas;
  logic             tgl_prev_q;
  logic             strobe;
  logic [CNT_W-1:0] cnt;
  logic             ovf;

  clkchk_ctrl u_ctrl (
    .clk_i      (clk_meas_i),
    .rst_ni     (rst_meas_ni),
    .enable_i   (enable_i),
    .echo_i     (echo),
    .req_o      (req),
    .count_en_o (count_en)
  );

  clkchk_ref_window #(.WIN_CYC(WIN_CYC)) u_ref_win (
    .clk_ref_i  (clk_ref_i),
    .rst_ref_ni (rst_ref_ni),
    .req_i      (req),
    .en_ref_o   (en_ref),
    .tick_tgl_o (tgl_ref)
  );

  clkchk_sync2 #(.W(1)) u_echo_sync (
    .clk_i  (clk_meas_i),
    .rst_ni (rst_meas_ni),
    .d_i    (en_ref),
    .q_o    (echo)
  );

  clkchk_sync2 #(.W(1)) u_tick_sync (
    .clk_i  (clk_meas_i),
    .rst_ni (rst_meas_ni),
    .d_i    (tgl_ref),
    .q_o    (tgl_meas)
  );

  always_ff @(posedge clk_meas_i or negedge rst_meas_ni) begin
    if (!rst_meas_ni) tgl_prev_q <= 1'b0;
    else              tgl_prev_q <= tgl_meas;
  end

  assign strobe = tgl_meas ^ tgl_prev_q;

  clkchk_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_meas_i),
    .rst_ni     (rst_meas_ni),
    .count_en_i (count_en),
    .strobe_i   (strobe),
    .cnt_o      (cnt),
    .ovf_o      (ovf)
  );

  assign result_valid_o = strobe & (|cnt);
  assign too_fast_o     = result_valid_o & ((cnt > hi_bound_i) | ovf);
  assign too_slow_o     = result_valid_o & (cnt < lo_bound_i);

  AST_VALID_SINGLE: assert property (@(posedge clk_meas_i) disable iff (!rst_meas_ni)
    result_valid_o |=> !result_valid_o); // R8
  AST_FAST_QUALIFIED: assert property (@(posedge clk_meas_i) disable iff (!rst_meas_ni)
    too_fast_o |-> result_valid_o); // R9
  AST_SLOW_QUALIFIED: assert property (@(posedge clk_meas_i) disable iff (!rst_meas_ni)
    too_slow_o |-> result_valid_o); // R10
  AST_QUIET_IN_RESET: assert property (@(posedge clk_meas_i)
    !rst_meas_ni |-> !result_valid_o && !too_fast_o && !too_slow_o); // R1

endmodule

// File: tb/clk_rate_check_bench.sv
module clk_rate_check_bench;

  localparam int CW  = 6;
  localparam int WIN = 4;
  localparam int MAXC = (1 << CW) - 1;
  localparam int GAP = 200;

  typedef struct {
    bit    skip;
    bit    fast;
    bit    slow;
    string tag;
  } exp_t;

  logic          clk_meas;
  logic          clk_ref;
  logic          rst_n;
  logic          en;
  logic [CW-1:0] lo_b;
  logic [CW-1:0] hi_b;
  logic          valid, fast, slow;

  int   ratio;
  int   rcnt;
  int   n_checks;
  int   n_fails;
  int   stray;
  bit   prev_valid;
  bit   done;
  exp_t sb_q[$];

  clk_rate_check #(.CNT_W(CW), .WIN_CYC(WIN)) u_clk_rate_check (
    .clk_meas_i     (clk_meas),
    .rst_meas_ni    (rst_n),
    .enable_i       (en),
    .clk_ref_i      (clk_ref),
    .rst_ref_ni     (rst_n),
    .lo_bound_i     (lo_b),
    .hi_bound_i     (hi_b),
    .result_valid_o (valid),
    .too_fast_o     (fast),
    .too_slow_o     (slow)
  );

  initial clk_meas = 1'b0;
  always #5 clk_meas = ~clk_meas;

  // Reference clock: one rising edge every `ratio` measured cycles, on measured falling edges.
  initial begin
    clk_ref = 1'b0;
    rcnt    = 0;
    ratio   = 3;
  end
  always @(negedge clk_meas) begin
    int nxt;
    nxt = (rcnt >= ratio - 1) ? 0 : rcnt + 1;
    rcnt    <= nxt;
    clk_ref <= (nxt < (ratio / 2)) || (nxt == 0);
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Monitor: pops one expected item per result strobe.
  always @(negedge clk_meas) begin
    if (rst_n) begin
      if (valid) begin
        check(!prev_valid, "R8 single-cycle valid", 1, 0);
        if (sb_q.size() == 0) begin
          stray++;
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          if (!e.skip) begin
            check(fast == e.fast, {e.tag, " too_fast"}, int'(fast), int'(e.fast));
            check(slow == e.slow, {e.tag, " too_slow"}, int'(slow), int'(e.slow));
          end
        end
      end
      prev_valid <= valid;
    end else begin
      prev_valid <= 1'b0;
    end
  end

  // Driver: one enable session, expected flags derived from R5, R7, R9, R10.
  task automatic run_session(input int r, input int lo, input int hi, input int nwin, input string tag);
    int   full, cntv, base;
    exp_t e;
    bit   f, s;
    ratio = r;
    lo_b  = CW'(lo);
    hi_b  = CW'(hi);
    full  = WIN * r - 1;
    if (full > MAXC) begin
      cntv = MAXC;
      f    = 1'b1;
    end else begin
      cntv = full;
      f    = (cntv > hi);
    end
    s = (cntv < lo);
    e.skip = 1'b1; e.fast = 1'b0; e.slow = 1'b0; e.tag = tag;
    sb_q.push_back(e);
    for (int i = 0; i < nwin; i++) begin
      e.skip = 1'b0; e.fast = f; e.slow = s; e.tag = tag;
      sb_q.push_back(e);
    end
    repeat (3) @(negedge clk_meas);
    en = 1'b1;
    while (sb_q.size() != 0) @(negedge clk_meas);
    repeat (2) @(negedge clk_meas);
    en   = 1'b0;
    base = stray;
    repeat (GAP) @(negedge clk_meas);
    check(stray == base, "R3 no result after disable handshake", stray - base, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_meas);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base;
    n_checks = 0; n_fails = 0; stray = 0; done = 1'b0; prev_valid = 1'b0;
    rst_n = 1'b0; en = 1'b0; lo_b = '0; hi_b = '0;
    repeat (5) @(negedge clk_meas);
    check(!valid && !fast && !slow, "R1 outputs low in reset", int'({valid, fast, slow}), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk_meas);
    check(stray == 0 && !valid, "R1 idle after reset", stray, 0);

    // Count 11 at both exact bounds: neither flag.
    run_session(3, 11, 11, 3, "R2 R5 R9 R10 exact bounds");
    // Count 11 above upper bound 10.
    run_session(3, 0, 10, 3, "R9 fast");
    // Count 11 below lower bound 12.
    run_session(3, 12, MAXC, 3, "R10 slow");
    // Ratio 5: count 19 inside [15,25].
    run_session(5, 15, 25, 3, "R5 ratio 5 in range");

    // One-cycle enable pulse: handshake completes, nothing reported.
    ratio = 5;
    repeat (3) @(negedge clk_meas);
    base = stray;
    en = 1'b1;
    @(negedge clk_meas);
    en = 1'b0;
    repeat (GAP) @(negedge clk_meas);
    check(stray == base, "R11 short enable pulse gives no result", stray - base, 0);

    // Ratio 20: 79 edges per window overflows a 6-bit count; fast despite hi = max.
    run_session(20, 0, MAXC, 3, "R7 overflow reported fast");
    // Back to ratio 3 after overflow: counter and flag start clean.
    run_session(3, 11, 11, 3, "R4 R6 R11 clean after overflow");
    // Ratio 7: count 27 below 30.
    run_session(7, 30, 40, 3, "R10 ratio 7 slow");

    finish_run();
  end

endmodule